// File: doc/BRIEF.md
# Dual-Input Up-Down Cascadable Counter

This block is a reversible binary counter driven by two count inputs instead of a clock and a direction pin. A rising edge on the up input adds one. A rising edge on the down input subtracts one. An edge counts only while the other input rests high. All count bits are held in one register and change on the same system clock edge.

Both count inputs are asynchronous to the system clock. Each passes through a flop synchronizer and a rising-edge detector before it can cause a count. A clear input and an active-low preset input act at once on the count output and override counting. The preset lets the counter divide by N. Clear takes priority over preset.

Two active-low outputs support cascading. The carry output goes low while the count is at its maximum and the up input is low. The borrow output goes low while the count is zero and the down input is low. Wire carry and borrow of one stage to the up and down inputs of the next stage, and the stages form a wider counter with no extra logic.

Top module: `updn_pair_counter`

## Requirements
- R1: The count `q` is WIDTH bits wide (default 4) and is 0 after `rst_n` is asserted. On every clock edge, all bits of the held count update together.
- R2: A rising edge on `up_in` while `dn_in` is high increments `q` by one. The new value appears after the third rising edge of `clk` following the input edge (two synchronizer flops plus the count register, with default SYNC_STAGES=2).
- R3: A rising edge on `dn_in` while `up_in` is high decrements `q` by one, with the same latency as R2.
- R4: While `clr` is high, `q` is 0 at once, whatever `load_n`, `din` and the count inputs do. The held count is 0 after the next clock edge.
- R5: While `load_n` is low and `clr` is low, `q` equals `din` at once, without waiting for a clock edge. When `load_n` is released, the last loaded value is kept.
- R6: `borrow_n` is low exactly when `q` is 0 and `dn_in` is low. It is high at all other times.
- R7: `carry_n` is low exactly when `q` is 2^WIDTH-1 and `up_in` is low. It is high at all other times.
- R8: When `carry_n` and `borrow_n` of one stage drive `up_in` and `dn_in` of a second stage, the two stages count as one counter of 2*WIDTH bits, both upward and downward.
- R9: The count wraps modulo 2^WIDTH. Incrementing from 2^WIDTH-1 gives 0, and decrementing from 0 gives 2^WIDTH-1.
- R10: A count is ignored if both inputs rise within the same sampled cycle. A count is also ignored if one input rises while the other input is low.
- R11: A count edge detected while `clr` is high or `load_n` is low is discarded. Counting resumes with the first qualifying edge after both controls are released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the count inputs |
| rst_n | input | 1 | Active-low asynchronous system reset |
| up_in | input | 1 | Up count input, counts on a rising edge |
| dn_in | input | 1 | Down count input, counts on a rising edge |
| clr | input | 1 | Active-high clear, highest priority |
| load_n | input | 1 | Active-low preset enable |
| din | input | WIDTH | Preset data |
| q | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low carry for cascading |
| borrow_n | output | 1 | Active-low borrow for cascading |

## Verification
A wrong held count shows on `q` at the sampling point three clock edges after the count edge that caused it. Because `q` is never re-derived, the error stays until the next clear or preset. A misdecoded maximum or zero shows at once on `carry_n` or `borrow_n` as soon as the matching count input is held low. In a cascade, that error becomes a lost or extra count in the upper stage. Sweeping every preset value through an increment and a decrement exposes every wrong transition and every wrap error within one pulse.

// File: rtl/updn_pkg.sv
package updn_pkg;
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_INC  = 2'd1,
      STEP_DEC  = 2'd2
   } step_t;
endpackage

// File: rtl/updn_edge_sync.sv
module updn_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic level,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last <= 1'b1;
      else        last <= chain[STAGES-1];
   end

   assign level = chain[STAGES-1];
   assign rise  = chain[STAGES-1] & ~last;
endmodule

// File: rtl/updn_step_qual.sv
module updn_step_qual
   import updn_pkg::*;
(
   input  logic  up_rise,
   input  logic  dn_rise,
   input  logic  up_level,
   input  logic  dn_level,
   input  logic  clr,
   input  logic  load_n,
   output step_t step
);
   logic ctrl_free;
   assign ctrl_free = ~clr & load_n;

   always_comb begin
      step = STEP_HOLD;
      if (ctrl_free) begin
         if (up_rise && !dn_rise && dn_level)      step = STEP_INC;
         else if (dn_rise && !up_rise && up_level) step = STEP_DEC;
      end
   end
endmodule

// File: rtl/updn_count_core.sv
module updn_count_core
   import updn_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load_n,
   input  logic [WIDTH-1:0] din,
   input  step_t            step,
   output logic [WIDTH-1:0] q
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
   logic [WIDTH-1:0] held;
   logic [WIDTH-1:0] nxt;

   always_comb begin
      unique case (step)
         STEP_INC: nxt = held + ONE;
         STEP_DEC: nxt = held - ONE;
         default:  nxt = held;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       held <= '0;
      else if (clr)     held <= '0;
      else if (!load_n) held <= din;
      else              held <= nxt;
   end

   always_comb begin
      if (clr)          q = '0;
      else if (!load_n) q = din;
      else              q = held;
   end
endmodule

// File: rtl/updn_cascade_out.sv
module updn_cascade_out #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] q,
   input  logic             up_in,
   input  logic             dn_in,
   output logic             carry_n,
   output logic             borrow_n
);
   localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
   assign carry_n  = ~((q == TOP) & ~up_in);
   assign borrow_n = ~((q == '0) & ~dn_in);
endmodule

// File: rtl/updn_pair_counter.sv
module updn_pair_counter
   import updn_pkg::*;
#(
   parameter int WIDTH       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_in,
   input  logic             dn_in,
   input  logic             clr,
   input  logic             load_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             carry_n,
   output logic             borrow_n
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("updn_pair_counter: WIDTH must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("updn_pair_counter: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic  up_lvl, up_rise, dn_lvl, dn_rise;
   step_t step;

   updn_edge_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
      .clk(clk), .rst_n(rst_n), .async_in(up_in), .level(up_lvl), .rise(up_rise));

   updn_edge_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
      .clk(clk), .rst_n(rst_n), .async_in(dn_in), .level(dn_lvl), .rise(dn_rise));

   updn_step_qual u_qual (
      .up_rise(up_rise), .dn_rise(dn_rise), .up_level(up_lvl), .dn_level(dn_lvl),
      .clr(clr), .load_n(load_n), .step(step));

   updn_count_core #(.WIDTH(WIDTH)) u_core (
      .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .din(din),
      .step(step), .q(q));

   updn_cascade_out #(.WIDTH(WIDTH)) u_casc (
      .q(q), .up_in(up_in), .dn_in(dn_in), .carry_n(carry_n), .borrow_n(borrow_n));
endmodule

// File: rtl/updn_pair_counter_chk.sv
module updn_pair_counter_chk #(
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             up_in,
   input logic             dn_in,
   input logic             clr,
   input logic             load_n,
   input logic [WIDTH-1:0] din,
   input logic [WIDTH-1:0] q,
   input logic             carry_n,
   input logic             borrow_n
);
   localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |-> (q == '0)); // R4
   AST_PRESET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load_n) |-> (q == din)); // R5
   AST_BORROW_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !borrow_n |-> (q == '0 && !dn_in)); // R6
   AST_CARRY_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      !carry_n |-> (q == TOP && !up_in)); // R7
   AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !clr && load_n && $past(!clr && load_n) && !$stable(q))
         |-> (q == $past(q) + ONE || q == $past(q) - ONE)); // R9
endmodule

bind updn_pair_counter updn_pair_counter_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .up_in(up_in), .dn_in(dn_in), .clr(clr),
   .load_n(load_n), .din(din), .q(q), .carry_n(carry_n), .borrow_n(borrow_n));

// File: tb/sim_updn_pair_counter.sv
`timescale 1ns/1ps
module sim_updn_pair_counter;
   localparam int W = 4;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic up_in = 1'b1, dn_in = 1'b1, clr = 1'b0, load_n = 1'b1;
   logic [W-1:0] din = '0;
   logic [W-1:0] q;
   logic carry_n, borrow_n;
   logic clr1 = 1'b0, load1_n = 1'b1;
   logic [W-1:0] q1;
   logic c1_n, b1_n;
   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   updn_pair_counter #(.WIDTH(W)) u0 (
      .clk(clk), .rst_n(rst_n), .up_in(up_in), .dn_in(dn_in), .clr(clr),
      .load_n(load_n), .din(din), .q(q), .carry_n(carry_n), .borrow_n(borrow_n));

   updn_pair_counter #(.WIDTH(W)) u1 (
      .clk(clk), .rst_n(rst_n), .up_in(carry_n), .dn_in(borrow_n), .clr(clr1),
      .load_n(load1_n), .din('0), .q(q1), .carry_n(c1_n), .borrow_n(b1_n));

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse_up();
      @(negedge clk); up_in = 1'b0;
      repeat (4) @(negedge clk); up_in = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_dn();
      @(negedge clk); dn_in = 1'b0;
      repeat (4) @(negedge clk); dn_in = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic preset(input int v);
      @(negedge clk); din = W'(v); load_n = 1'b0;
      #1 chk("R5 immediate preset", int'(q), v);
      @(negedge clk); load_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset count", int'(q), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 idle after reset", int'(q), 0);
      chk("R7 carry idle", int'(carry_n), 1);
      chk("R6 borrow idle", int'(borrow_n), 1);

      for (int v = 0; v < 16; v++) begin
         preset(v);
         chk("R5 preset held", int'(q), v);
         @(negedge clk); up_in = 1'b0;
         #1 chk("R7 carry level", int'(carry_n), (v == 15) ? 0 : 1);
         chk("R6 borrow unaffected by up", int'(borrow_n), 1);
         repeat (4) @(negedge clk); up_in = 1'b1;
         #1 chk("R7 carry released", int'(carry_n), 1);
         repeat (2) @(negedge clk);
         chk("R2 not before third edge", int'(q), v);
         repeat (2) @(negedge clk);
         chk("R2/R9 increment", int'(q), (v + 1) % 16);
         preset(v);
         @(negedge clk); dn_in = 1'b0;
         #1 chk("R6 borrow level", int'(borrow_n), (v == 0) ? 0 : 1);
         repeat (4) @(negedge clk); dn_in = 1'b1;
         repeat (4) @(negedge clk);
         chk("R3/R9 decrement", int'(q), (v + 15) % 16);
      end

      preset(7);
      @(negedge clk); up_in = 1'b0; dn_in = 1'b0;
      repeat (4) @(negedge clk); up_in = 1'b1; dn_in = 1'b1;
      repeat (5) @(negedge clk);
      chk("R10 simultaneous rise ignored", int'(q), 7);

      @(negedge clk); dn_in = 1'b0;
      repeat (4) @(negedge clk);
      pulse_up();
      chk("R10 up rise with down low ignored", int'(q), 7);
      dn_in = 1'b1;
      repeat (5) @(negedge clk);
      chk("R3 later down rise counts", int'(q), 6);

      @(negedge clk); din = 4'd5; load_n = 1'b0;
      pulse_up();
      chk("R11 preset during edge", int'(q), 5);
      load_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R11 edge discarded", int'(q), 5);
      pulse_up();
      chk("R11 resumes", int'(q), 6);

      @(negedge clk); din = 4'd9; load_n = 1'b0; clr = 1'b1;
      #1 chk("R4 clear beats preset", int'(q), 0);
      pulse_dn();
      load_n = 1'b1;
      @(negedge clk); clr = 1'b0;
      repeat (4) @(negedge clk);
      chk("R4/R11 after clear", int'(q), 0);

      preset(0);
      @(negedge clk); clr1 = 1'b1;
      @(negedge clk); clr1 = 1'b0;
      repeat (2) @(negedge clk);
      for (int k = 0; k < 20; k++) pulse_up();
      chk("R8 cascade up total", int'(q1) * 16 + int'(q), 20);
      for (int k = 0; k < 25; k++) pulse_dn();
      chk("R8 cascade down total", int'(q1) * 16 + int'(q), 251);

      finish_run();
   end
endmodule